// File: doc/BRIEF.md
# On-chip program memory size controller with timed-access protection

This block decides, for every program fetch, whether the fetch is served by the on-chip program memory or sent to the external memory bus. A 3-bit size code sets how much of the low program space is on-chip, from none at all up to the full 64kB. The code sits in a special-function register. That register can be changed only inside a short window, and the window opens only after a fixed two-byte key has been written to a separate timed-access register. This guards against a stray write moving the memory map.

A size write that is accepted does not move the boundary at once. The new code waits in a pending stage and takes over fetch routing only after two machine-cycle ticks. This gives the processor time to finish the instructions it has already fetched before the map changes. Reads of the size register return the code that currently governs routing.

The processor core supplies the special-register write bus, a one-clock machine-cycle tick and each fetch address. The memory arrays and the interrupt logic are outside this block.

Top module: `rsz_rom_sizer`

## Requirements
- R1: After reset the effective size code is 3'b111 (64kB), so every valid fetch is internal, and the unlock window is closed.
- R2: The size code maps to an on-chip limit: 000=0, 001=1kB, 010=2kB, 011=4kB, 100=8kB, 101=16kB, 110=32kB, 111=64kB. A valid fetch below the limit raises fetch_int. A valid fetch at or above the limit raises fetch_ext. At most one of the two is high, and neither is high when fetch_vld is low.
- R3: Code 000 sends every fetch to the external bus. Code 001 keeps addresses 0000h–03FFh internal and sends 0400h upward to the external bus.
- R4: A write to the size register (address C2h) while the window is closed has no effect on the size code.
- R5: Writing AAh and then 55h to the timed-access register (address C7h) opens the window. A size write made while the window is open is accepted, and only data bits [2:0] are taken as the new code.
- R6: The unlock sequence restarts from the beginning after any of these: a timed-access write of a byte other than AAh or 55h, a 55h that does not directly follow AAh, or a size write made before the window opens.
- R7: Writing AAh to the timed-access register always restarts the sequence at its second step. This holds after an earlier AAh, and it also holds while the window is open, which closes the window.
- R8: The window stays open until the third machine-cycle tick after the 55h write. A size write in the same clock as that third tick is accepted. A size write after it is ignored.
- R9: An accepted size write closes the window, so each unlock admits exactly one size write.
- R10: An accepted code governs routing from the clock edge of the second tick after the write. A tick in the write's own clock does not count. A new accepted write during the delay replaces the pending code and restarts the delay.
- R11: A read of the size register (sfr_addr = C2h) returns the effective code on bits [2:0] with the upper bits zero. While a code is still pending, the read returns the old effective code.
- R12: Writes to special-register addresses other than C2h and C7h neither advance nor restart the unlock sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sfr_we | input | 1 | Special-register write strobe |
| sfr_addr | input | 8 | Special-register address, for both read and write |
| sfr_wdata | input | 8 | Special-register write data |
| sfr_rdata | output | 8 | Read data: the effective size code when sfr_addr is C2h, otherwise zero |
| cyc_tick | input | 1 | One-clock pulse per machine cycle |
| fetch_vld | input | 1 | A program fetch is presented |
| fetch_addr | input | 16 | Program fetch address |
| fetch_int | output | 1 | Fetch is served by on-chip memory |
| fetch_ext | output | 1 | Fetch goes to the external bus |
| size_code | output | 3 | Effective size code |

## Verification
Two events can land in the same clock: the machine-cycle tick that ends the unlock window, and the protected size write. The bench opens the window, sends two ticks, and then drives the size write together with the third tick in a single clock. It checks that the write is accepted. It also checks that the tick in that clock does not count toward the two-tick delay, so the new code appears only after two further ticks. A matching case sends the write one tick later and expects the code to stay unchanged. This separates window timing that is off by one in either direction.

// File: rtl/rsz_pkg.sv
package rsz_pkg;

  localparam int CODE_W = 3;

  typedef enum logic [1:0] {
    TA_IDLE  = 2'd0,
    TA_ARMED = 2'd1,
    TA_OPEN  = 2'd2
  } ta_state_e;

  // On-chip limit in bytes for a size code: 0 for code 0, otherwise
  // 2**(min_log + code - 1), saturated at the full address space.
  function automatic logic [31:0] size_limit(input logic [CODE_W-1:0] code,
                                             input int unsigned min_log,
                                             input int unsigned addr_w);
    int unsigned sh;
    if (code == '0) return 32'd0;
    sh = min_log + {29'd0, code} - 32'd1;
    if (sh >= addr_w) return 32'd1 << addr_w;
    return 32'd1 << sh;
  endfunction

endpackage

// File: rtl/rsz_unlock.sv
module rsz_unlock
  import rsz_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter logic [7:0]  TA_ADDR   = 8'hC7,
  parameter logic [7:0]  SZ_ADDR   = 8'hC2,
  parameter logic [7:0]  KEY_FIRST = 8'hAA,
  parameter logic [7:0]  KEY_SECOND= 8'h55,
  parameter int unsigned WIN_TICKS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sfr_we,
  input  logic [7:0]        sfr_addr,
  input  logic [DATA_W-1:0] sfr_wdata,
  input  logic              cyc_tick,
  output logic              grant,
  output logic              win_open
);

  localparam int unsigned CNT_W = $clog2(WIN_TICKS + 1);

  ta_state_e        st_q;
  logic [CNT_W-1:0] win_cnt_q;

  // Named events for the assertions.
  logic ta_wr, sz_wr, hit_first, hit_second, win_expire;

  assign ta_wr      = sfr_we && (sfr_addr == TA_ADDR);
  assign sz_wr      = sfr_we && (sfr_addr == SZ_ADDR);
  assign hit_first  = ta_wr && (sfr_wdata[7:0] == KEY_FIRST);
  assign hit_second = ta_wr && (sfr_wdata[7:0] == KEY_SECOND) && (st_q == TA_ARMED);
  assign win_open   = (st_q == TA_OPEN);
  // A size write in the closing tick's clock still sees the window open.
  assign grant      = sz_wr && win_open;
  assign win_expire = win_open && !ta_wr && !sz_wr && cyc_tick &&
                      (win_cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= TA_IDLE;
      win_cnt_q <= '0;
    end else if (ta_wr) begin
      if (hit_first) begin
        st_q <= TA_ARMED;
      end else if (hit_second) begin
        st_q      <= TA_OPEN;
        win_cnt_q <= CNT_W'(WIN_TICKS);
      end else begin
        st_q <= TA_IDLE;
      end
    end else if (sz_wr) begin
      // Accepted or not, a size write ends the sequence.
      st_q <= TA_IDLE;
    end else if (win_open && cyc_tick) begin
      if (win_expire) st_q <= TA_IDLE;
      win_cnt_q <= win_cnt_q - CNT_W'(1);
    end
  end

  a_r7_first_key_arms: assert property (@(posedge clk) disable iff (!rst_n)
    hit_first |=> (st_q == TA_ARMED));

  a_r8_open_follows_second_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win_open) |-> $past(ta_wr && (sfr_wdata[7:0] == KEY_SECOND)));

  a_r9_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> !win_open);

  a_r6_stray_byte_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (ta_wr && !hit_first && !hit_second) |=> (st_q == TA_IDLE));

endmodule

// File: rtl/rsz_size_reg.sv
module rsz_size_reg #(
  parameter int unsigned CODE_W      = 3,
  parameter int unsigned DELAY_TICKS = 2,
  parameter logic [CODE_W-1:0] RESET_CODE = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              grant,
  input  logic [CODE_W-1:0] new_code,
  input  logic              cyc_tick,
  output logic [CODE_W-1:0] eff_code,
  output logic              pending
);

  localparam int unsigned PC_W = $clog2(DELAY_TICKS + 1);

  logic [CODE_W-1:0] eff_q, pend_q;
  logic [PC_W-1:0]   pcnt_q;
  logic              apply;

  assign pending = (pcnt_q != '0);
  // A grant in the same clock restarts the delay, so it beats the apply.
  assign apply   = !grant && cyc_tick && (pcnt_q == PC_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eff_q  <= RESET_CODE;
      pend_q <= RESET_CODE;
      pcnt_q <= '0;
    end else if (grant) begin
      pend_q <= new_code;
      pcnt_q <= PC_W'(DELAY_TICKS);
    end else if (cyc_tick && pending) begin
      pcnt_q <= pcnt_q - PC_W'(1);
      if (apply) eff_q <= pend_q;
    end
  end

  assign eff_code = eff_q;

  a_r10_hold_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> (eff_q == $past(eff_q)));

  a_r10_change_only_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_tick |=> (eff_q == $past(eff_q)));

  a_r4_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant && !pending) |=> $stable(eff_q));

endmodule

// File: rtl/rsz_fetch_route.sv
module rsz_fetch_route
  import rsz_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned MIN_LOG = 10
) (
  input  logic              rst_n,
  input  logic              fetch_vld,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic [CODE_W-1:0] code,
  output logic              fetch_int,
  output logic              fetch_ext
);

  logic [31:0] limit;
  logic        in_range;

  assign limit     = size_limit(code, MIN_LOG, ADDR_W);
  assign in_range  = ({{(32-ADDR_W){1'b0}}, fetch_addr} < limit);
  assign fetch_int = fetch_vld && in_range;
  assign fetch_ext = fetch_vld && !in_range;

  always_comb begin
    if (rst_n) begin
      a_r2_exclusive: assert (!(fetch_int && fetch_ext));
      if (fetch_vld && code == '0)
        a_r3_zero_all_ext: assert (fetch_ext);
    end
  end

endmodule

// File: rtl/rsz_rom_sizer.sv
module rsz_rom_sizer
  import rsz_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned MIN_LOG     = 10,
  parameter logic [7:0]  TA_ADDR     = 8'hC7,
  parameter logic [7:0]  SZ_ADDR     = 8'hC2,
  parameter logic [7:0]  KEY_FIRST   = 8'hAA,
  parameter logic [7:0]  KEY_SECOND  = 8'h55,
  parameter int unsigned WIN_TICKS   = 3,
  parameter int unsigned DELAY_TICKS = 2,
  parameter logic [2:0]  RESET_CODE  = 3'b111
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sfr_we,
  input  logic [7:0]        sfr_addr,
  input  logic [DATA_W-1:0] sfr_wdata,
  output logic [DATA_W-1:0] sfr_rdata,
  input  logic              cyc_tick,
  input  logic              fetch_vld,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              fetch_int,
  output logic              fetch_ext,
  output logic [CODE_W-1:0] size_code
);

  logic              grant, win_open, pending;
  logic [CODE_W-1:0] eff_code;

  rsz_unlock #(
    .DATA_W(DATA_W), .TA_ADDR(TA_ADDR), .SZ_ADDR(SZ_ADDR),
    .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND), .WIN_TICKS(WIN_TICKS)
  ) u_unlock (
    .clk(clk), .rst_n(rst_n), .sfr_we(sfr_we), .sfr_addr(sfr_addr),
    .sfr_wdata(sfr_wdata), .cyc_tick(cyc_tick),
    .grant(grant), .win_open(win_open)
  );

  rsz_size_reg #(
    .CODE_W(CODE_W), .DELAY_TICKS(DELAY_TICKS), .RESET_CODE(RESET_CODE)
  ) u_size (
    .clk(clk), .rst_n(rst_n), .grant(grant),
    .new_code(sfr_wdata[CODE_W-1:0]), .cyc_tick(cyc_tick),
    .eff_code(eff_code), .pending(pending)
  );

  rsz_fetch_route #(.ADDR_W(ADDR_W), .MIN_LOG(MIN_LOG)) u_route (
    .rst_n(rst_n), .fetch_vld(fetch_vld), .fetch_addr(fetch_addr),
    .code(eff_code), .fetch_int(fetch_int), .fetch_ext(fetch_ext)
  );

  assign size_code = eff_code;
  assign sfr_rdata = (sfr_addr == SZ_ADDR) ? {{(DATA_W-CODE_W){1'b0}}, eff_code} : '0;

  a_r11_read_is_effective: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && $past(grant)) |-> (size_code == $past(size_code)));

  a_r1_window_closed_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !win_open);

endmodule

// File: tb/rsz_rom_sizer_bench.sv
module rsz_rom_sizer_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] TA = 8'hC7;
  localparam logic [7:0] SZ = 8'hC2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sfr_we = 1'b0;
  logic [7:0]  sfr_addr = 8'h00;
  logic [7:0]  sfr_wdata = 8'h00;
  logic [7:0]  sfr_rdata;
  logic        cyc_tick = 1'b0;
  logic        fetch_vld = 1'b0;
  logic [15:0] fetch_addr = 16'h0000;
  logic        fetch_int, fetch_ext;
  logic [2:0]  size_code;

  int n_total = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rsz_rom_sizer u_rsz_rom_sizer (
    .clk(clk), .rst_n(rst_n), .sfr_we(sfr_we), .sfr_addr(sfr_addr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .cyc_tick(cyc_tick),
    .fetch_vld(fetch_vld), .fetch_addr(fetch_addr),
    .fetch_int(fetch_int), .fetch_ext(fetch_ext), .size_code(size_code)
  );

  function automatic int unsigned exp_limit(input logic [2:0] c);
    case (c)
      3'd0: return 0;
      3'd1: return 'h400;
      3'd2: return 'h800;
      3'd3: return 'h1000;
      3'd4: return 'h2000;
      3'd5: return 'h4000;
      3'd6: return 'h8000;
      default: return 'h10000;
    endcase
  endfunction

  task automatic check(input string tag, input int unsigned act, input int unsigned exp);
    n_total++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // One clock with the given inputs; inputs return to idle just after the edge.
  task automatic cyc(input bit t, input bit we, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cyc_tick = t; sfr_we = we; sfr_addr = a; sfr_wdata = d;
    @(posedge clk);
    #1;
    cyc_tick = 1'b0; sfr_we = 1'b0; sfr_addr = 8'h00; sfr_wdata = 8'h00;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d); cyc(1'b0, 1'b1, a, d); endtask
  task automatic tk(); cyc(1'b1, 1'b0, 8'h00, 8'h00); endtask
  task automatic unlock(); wr(TA, 8'hAA); wr(TA, 8'h55); endtask

  task automatic check_size(input string tag, input logic [2:0] exp);
    sfr_addr = SZ;
    #1;
    check({tag, " size_code"}, size_code, exp);
    check({tag, " read"}, sfr_rdata, {5'b0, exp});
    sfr_addr = 8'h00;
  endtask

  task automatic check_fetch(input string tag, input logic [15:0] a, input bit exp_int);
    fetch_vld = 1'b1; fetch_addr = a;
    #1;
    check(tag, {fetch_int, fetch_ext}, {exp_int, !exp_int});
    fetch_vld = 1'b0;
  endtask

  task automatic set_size(input logic [2:0] c);
    unlock(); wr(SZ, {5'b0, c}); tk(); tk();
  endtask

  task automatic t_reset();
    check_size("R1 reset", 3'b111);
    check_fetch("R1 reset top fetch", 16'hFFFF, 1'b1);
    check_fetch("R1 reset low fetch", 16'h0000, 1'b1);
    fetch_vld = 1'b0; fetch_addr = 16'h1234;
    #1;
    check("R2 no fetch no select", {fetch_int, fetch_ext}, 2'b00);
  endtask

  task automatic t_locked();
    wr(SZ, 8'h03); tk(); tk(); tk();
    check_size("R4 locked write ignored", 3'b111);
    check_fetch("R4 routing unchanged", 16'hF000, 1'b1);
  endtask

  task automatic t_unlock_delay();
    unlock();
    wr(SZ, 8'hF3);
    check_size("R11 pending read old", 3'b111);
    tk();
    check_size("R10 one tick not yet", 3'b111);
    check_fetch("R10 route old before delay", 16'h1000, 1'b1);
    tk();
    check_size("R5 low bits taken", 3'b011);
    check_fetch("R2 4kB below", 16'h0FFF, 1'b1);
    check_fetch("R2 4kB at limit", 16'h1000, 1'b0);
  endtask

  task automatic t_single();
    wr(SZ, 8'h05); tk(); tk(); tk();
    check_size("R9 second write ignored", 3'b011);
  endtask

  task automatic t_small();
    set_size(3'd0);
    check_fetch("R3 zero low ext", 16'h0000, 1'b0);
    check_fetch("R3 zero top ext", 16'hFFFF, 1'b0);
    set_size(3'd1);
    check_fetch("R3 1kB last int", 16'h03FF, 1'b1);
    check_fetch("R3 1kB first ext", 16'h0400, 1'b0);
  endtask

  task automatic t_wrong();
    wr(TA, 8'hAA); wr(TA, 8'h12); wr(TA, 8'h55); wr(SZ, 8'h06); tk(); tk();
    check_size("R6 wrong byte restarts", 3'b001);
    wr(TA, 8'hAA); wr(SZ, 8'h06); wr(TA, 8'h55); wr(SZ, 8'h06); tk(); tk();
    check_size("R6 early size write restarts", 3'b001);
    wr(TA, 8'h55); wr(SZ, 8'h06); tk(); tk();
    check_size("R6 lone second key", 3'b001);
  endtask

  task automatic t_restart();
    wr(TA, 8'hAA); wr(TA, 8'hAA); wr(TA, 8'h55); wr(SZ, 8'h02); tk(); tk();
    check_size("R7 double first key opens", 3'b010);
    unlock(); wr(TA, 8'hAA); wr(SZ, 8'h06); tk(); tk();
    check_size("R7 first key closes window", 3'b010);
  endtask

  // Window end and size write in the same clock.
  task automatic t_window();
    unlock(); tk(); tk();
    cyc(1'b1, 1'b1, SZ, 8'h04);
    tk();
    check_size("R8 tick in write clock not counted", 3'b010);
    tk();
    check_size("R8 write on closing tick accepted", 3'b100);
    unlock(); tk(); tk(); tk();
    wr(SZ, 8'h06); tk(); tk();
    check_size("R8 write after window ignored", 3'b100);
  endtask

  task automatic t_other();
    wr(TA, 8'hAA); wr(8'h80, 8'h11); wr(TA, 8'h55); wr(8'h90, 8'hAA); wr(SZ, 8'h05); tk(); tk();
    check_size("R12 other addresses transparent", 3'b101);
  endtask

  task automatic t_repend();
    unlock(); wr(SZ, 8'h06); tk();
    unlock(); wr(SZ, 8'h02); tk();
    check_size("R10 rewrite restarts delay", 3'b101);
    tk();
    check_size("R10 latest code applied", 3'b010);
  endtask

  task automatic t_sweep();
    for (int c = 0; c < 8; c++) begin
      int unsigned lim;
      set_size(3'(c));
      lim = exp_limit(3'(c));
      if (lim != 0) check_fetch($sformatf("R2 code %0d last int", c), 16'(lim - 1), 1'b1);
      if (lim < 'h10000) check_fetch($sformatf("R2 code %0d first ext", c), 16'(lim), 1'b0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_total++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_locked();
    t_unlock_delay();
    t_single();
    t_small();
    t_wrong();
    t_restart();
    t_window();
    t_other();
    t_repend();
    t_sweep();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

endmodule